// File: doc/BRIEF.md
# Two-Master Flash Bus Arbiter

This block lets two masters share one parallel NOR flash device without ever driving its pins at the same time. A primary host owns the bus after reset. A secondary loader asks for the bus by raising a request line. The host side answers by turning off its own drivers first. It then returns the request as a grant. The loader passes that grant through a synchronizer and drives the flash only while the synchronized grant is high.

Each master has a start/done port that carries one read or one write. Each access lasts a fixed number of clock cycles, set by a parameter for that master. A read enables the flash output for the whole count and captures the data bus on the last cycle of the count. A write holds write-enable low for the whole count, with the data driven. A pin multiplexer places the active master's address, data and strobes on the flash pins. When neither master is active, the strobes are inactive and the data bus is released.

The loader's sequencer does not accept a new access until it has seen the grant fall again. Unused state encodings of the sequencer return it to idle.

Top module: `flash_share_top`

## Requirements
- R1: After reset, bus_req, bus_grant, host_drv, ldr_drv and fl_dq_oe are 0, and ldr_ready and host_ready are 1.
- R2: The loader drives the flash (ldr_drv=1) only while bus_grant is high. With the host idle, ldr_drv rises exactly SYNC_STAGES+2 cycles after bus_req rises.
- R3: bus_grant is the request returned by the host one cycle later, but only once host_drv is low. If a host access is running when bus_req rises, ldr_drv rises HOST_ACC+SYNC_STAGES+1 cycles after bus_req.
- R4: While bus_grant is high, host_drv is 0 and host_ready is 0. A host_start pulse given while host_ready is 0 is ignored and produces no host_done.
- R5: host_drv and ldr_drv are never high in the same cycle.
- R6: bus_req stays high from the cycle after an accepted ldr_start until ldr_done, and falls in the cycle after ldr_done.
- R7: After bus_req falls, ldr_ready stays 0 until the synchronized grant is low. An ldr_start given in that window is ignored, and bus_req stays low.
- R8: A read (wr=0) holds fl_oe_n low for exactly the master's access count (LDR_ACC or HOST_ACC). The rdata of that master holds the flash word at the address given.
- R9: A write (wr=1) holds fl_we_n low for exactly the master's access count, with fl_dq_oe=1 and the write data on fl_dq_o. A later read of the same address by the other master returns that data.
- R10: When no master drives, fl_ce_n, fl_we_n and fl_oe_n are 1 and fl_dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_start | input | 1 | Host access start pulse |
| host_wr | input | 1 | Host access is a write (1) or a read (0) |
| host_addr | input | AW | Host access address |
| host_wdata | input | DW | Host write data |
| host_ready | output | 1 | Host may start an access |
| host_done | output | 1 | One-cycle pulse at the end of a host access |
| host_rdata | output | DW | Host read result |
| ldr_start | input | 1 | Loader access start pulse |
| ldr_wr | input | 1 | Loader access is a write (1) or a read (0) |
| ldr_addr | input | AW | Loader access address |
| ldr_wdata | input | DW | Loader write data |
| ldr_ready | output | 1 | Loader may start an access |
| ldr_done | output | 1 | One-cycle pulse at the end of a loader access |
| ldr_rdata | output | DW | Loader read result |
| bus_req | output | 1 | Loader request line to the host side |
| bus_grant | output | 1 | Grant line from the host side |
| host_drv | output | 1 | Host drivers are enabled on the flash pins |
| ldr_drv | output | 1 | Loader drivers are enabled on the flash pins |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | DW | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | DW | Flash data in |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The bench builds the block with a 4-bit address, an 8-bit data bus, a host access count of 3, a loader access count of 5 and two synchronizer stages. These values are small enough to sweep all sixteen addresses in both directions, with each master writing and the other reading back. They also keep the two access counts different, so a strobe width taken from the wrong master shows up. A host count of 3 gives a grant delay that differs from the idle-host case, so both handover latencies can be checked as exact cycle counts.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic [2:0] {
    LS_IDLE = 3'd0,
    LS_REQ  = 3'd1,
    LS_WAIT = 3'd2,
    LS_ACC  = 3'd3,
    LS_REL  = 3'd4
  } ldr_state_e;
endpackage

// File: rtl/fsh_cycle_engine.sv
module fsh_cycle_engine #(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int ACC_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          gate,
  input  logic [DW-1:0] dq_i,
  output logic          drv,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_dq_o,
  output logic          b_dq_oe,
  output logic          b_we_n,
  output logic          b_oe_n,
  output logic          b_ce_n
);
  localparam int CW = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACC_CYC - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          done_q, done_d;
  logic [DW-1:0] rd_q, rd_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = CNT_LOAD;
        wr_d   = wr;
        addr_d = addr;
        wd_d   = wdata;
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      if (!wr_q) rd_d = dq_i;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      done_q <= done_d;
      rd_q   <= rd_d;
    end
  end

  assign drv     = busy_q & gate;
  assign done    = done_q;
  assign rdata   = rd_q;
  assign b_addr  = addr_q;
  assign b_dq_o  = wd_q;
  assign b_dq_oe = drv & wr_q;
  assign b_we_n  = ~(drv & wr_q);
  assign b_oe_n  = ~(drv & ~wr_q);
  assign b_ce_n  = ~drv;

  // R8 / R9: completion only follows an access in progress
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/fsh_loader_req.sv
module fsh_loader_req
  import fsh_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int ACC_CYC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          grant_in,
  input  logic [DW-1:0] dq_i,
  output logic          req,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          drv,
  output logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_dq_o,
  output logic          b_dq_oe,
  output logic          b_we_n,
  output logic          b_oe_n,
  output logic          b_ce_n
);
  ldr_state_e st_q, st_d;
  logic [SYNC_STAGES-1:0] sy_q;
  logic          gs;
  logic          eng_start;
  logic          eng_done;
  logic          cmd_wr_q, cmd_wr_d;
  logic [AW-1:0] cmd_addr_q, cmd_addr_d;
  logic [DW-1:0] cmd_wd_q, cmd_wd_d;

  // grant synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= grant_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= {sy_q[SYNC_STAGES-2:0], grant_in};
      end
    end
  endgenerate
  assign gs = sy_q[SYNC_STAGES-1];

  always_comb begin
    st_d       = st_q;
    cmd_wr_d   = cmd_wr_q;
    cmd_addr_d = cmd_addr_q;
    cmd_wd_d   = cmd_wd_q;
    eng_start  = 1'b0;
    case (st_q)
      LS_IDLE: if (start) begin
        st_d       = LS_REQ;
        cmd_wr_d   = wr;
        cmd_addr_d = addr;
        cmd_wd_d   = wdata;
      end
      LS_REQ:  st_d = LS_WAIT;
      LS_WAIT: if (gs) begin
        st_d      = LS_ACC;
        eng_start = 1'b1;
      end
      LS_ACC:  if (eng_done) st_d = LS_REL;
      LS_REL:  if (!gs) st_d = LS_IDLE;
      default: st_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= LS_IDLE;
      cmd_wr_q   <= 1'b0;
      cmd_addr_q <= '0;
      cmd_wd_q   <= '0;
    end else begin
      st_q       <= st_d;
      cmd_wr_q   <= cmd_wr_d;
      cmd_addr_q <= cmd_addr_d;
      cmd_wd_q   <= cmd_wd_d;
    end
  end

  assign req   = (st_q == LS_REQ) || (st_q == LS_WAIT) || (st_q == LS_ACC);
  assign ready = (st_q == LS_IDLE);
  assign done  = eng_done;

  fsh_cycle_engine #(.AW(AW), .DW(DW), .ACC_CYC(ACC_CYC)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .wr      (cmd_wr_q),
    .addr    (cmd_addr_q),
    .wdata   (cmd_wd_q),
    .gate    (gs),
    .dq_i    (dq_i),
    .drv     (drv),
    .done    (eng_done),
    .rdata   (rdata),
    .b_addr  (b_addr),
    .b_dq_o  (b_dq_o),
    .b_dq_oe (b_dq_oe),
    .b_we_n  (b_we_n),
    .b_oe_n  (b_oe_n),
    .b_ce_n  (b_ce_n)
  );

  p_drive_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> gs && grant_in);
  p_req_drop_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(eng_done));
  p_ready_grant_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !gs);
endmodule

// File: rtl/fsh_host_grant.sv
module fsh_host_grant #(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int ACC_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          req_in,
  input  logic [DW-1:0] dq_i,
  output logic          grant,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          drv,
  output logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_dq_o,
  output logic          b_dq_oe,
  output logic          b_we_n,
  output logic          b_oe_n,
  output logic          b_ce_n
);
  logic grant_q, grant_d;
  logic eng_start;

  // grant echoes the request once the host's own drivers are off
  always_comb grant_d = req_in & ~drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= grant_d;
  end

  assign grant     = grant_q;
  assign ready     = ~req_in & ~grant_q & ~drv;
  assign eng_start = start & ready;

  fsh_cycle_engine #(.AW(AW), .DW(DW), .ACC_CYC(ACC_CYC)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .gate    (1'b1),
    .dq_i    (dq_i),
    .drv     (drv),
    .done    (done),
    .rdata   (rdata),
    .b_addr  (b_addr),
    .b_dq_o  (b_dq_o),
    .b_dq_oe (b_dq_oe),
    .b_we_n  (b_we_n),
    .b_oe_n  (b_oe_n),
    .b_ce_n  (b_ce_n)
  );

  p_host_off_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !drv);
  p_grant_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req_in));
endmodule

// File: rtl/fsh_pin_mux.sv
module fsh_pin_mux #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          h_drv,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_dq_o,
  input  logic          h_dq_oe,
  input  logic          h_we_n,
  input  logic          h_oe_n,
  input  logic          h_ce_n,
  input  logic          l_drv,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_dq_o,
  input  logic          l_dq_oe,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic          l_ce_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_ce_n
);
  always_comb begin
    fl_addr  = '0;
    fl_dq_o  = '0;
    fl_dq_oe = 1'b0;
    fl_we_n  = 1'b1;
    fl_oe_n  = 1'b1;
    fl_ce_n  = 1'b1;
    if (l_drv) begin
      fl_addr  = l_addr;
      fl_dq_o  = l_dq_o;
      fl_dq_oe = l_dq_oe;
      fl_we_n  = l_we_n;
      fl_oe_n  = l_oe_n;
      fl_ce_n  = l_ce_n;
    end else if (h_drv) begin
      fl_addr  = h_addr;
      fl_dq_o  = h_dq_o;
      fl_dq_oe = h_dq_oe;
      fl_we_n  = h_we_n;
      fl_oe_n  = h_oe_n;
      fl_ce_n  = h_ce_n;
    end
  end
endmodule

// File: rtl/flash_share_top.sv
module flash_share_top #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int HOST_ACC    = 4,
  parameter int LDR_ACC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_start,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  input  logic          ldr_start,
  input  logic          ldr_wr,
  input  logic [AW-1:0] ldr_addr,
  input  logic [DW-1:0] ldr_wdata,
  output logic          ldr_ready,
  output logic          ldr_done,
  output logic [DW-1:0] ldr_rdata,
  output logic          bus_req,
  output logic          bus_grant,
  output logic          host_drv,
  output logic          ldr_drv,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  logic [1:0]    rs_q;
  logic          rst_s_n;
  logic [AW-1:0] h_addr, l_addr;
  logic [DW-1:0] h_dq_o, l_dq_o;
  logic          h_dq_oe, h_we_n, h_oe_n, h_ce_n;
  logic          l_dq_oe, l_we_n, l_oe_n, l_ce_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  fsh_loader_req #(.AW(AW), .DW(DW), .ACC_CYC(LDR_ACC), .SYNC_STAGES(SYNC_STAGES)) u_ldr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (ldr_start),
    .wr       (ldr_wr),
    .addr     (ldr_addr),
    .wdata    (ldr_wdata),
    .grant_in (bus_grant),
    .dq_i     (fl_dq_i),
    .req      (bus_req),
    .ready    (ldr_ready),
    .done     (ldr_done),
    .rdata    (ldr_rdata),
    .drv      (ldr_drv),
    .b_addr   (l_addr),
    .b_dq_o   (l_dq_o),
    .b_dq_oe  (l_dq_oe),
    .b_we_n   (l_we_n),
    .b_oe_n   (l_oe_n),
    .b_ce_n   (l_ce_n)
  );

  fsh_host_grant #(.AW(AW), .DW(DW), .ACC_CYC(HOST_ACC)) u_host (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (host_start),
    .wr      (host_wr),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .req_in  (bus_req),
    .dq_i    (fl_dq_i),
    .grant   (bus_grant),
    .ready   (host_ready),
    .done    (host_done),
    .rdata   (host_rdata),
    .drv     (host_drv),
    .b_addr  (h_addr),
    .b_dq_o  (h_dq_o),
    .b_dq_oe (h_dq_oe),
    .b_we_n  (h_we_n),
    .b_oe_n  (h_oe_n),
    .b_ce_n  (h_ce_n)
  );

  fsh_pin_mux #(.AW(AW), .DW(DW)) u_mux (
    .h_drv    (host_drv),
    .h_addr   (h_addr),
    .h_dq_o   (h_dq_o),
    .h_dq_oe  (h_dq_oe),
    .h_we_n   (h_we_n),
    .h_oe_n   (h_oe_n),
    .h_ce_n   (h_ce_n),
    .l_drv    (ldr_drv),
    .l_addr   (l_addr),
    .l_dq_o   (l_dq_o),
    .l_dq_oe  (l_dq_oe),
    .l_we_n   (l_we_n),
    .l_oe_n   (l_oe_n),
    .l_ce_n   (l_ce_n),
    .fl_addr  (fl_addr),
    .fl_dq_o  (fl_dq_o),
    .fl_dq_oe (fl_dq_oe),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n),
    .fl_ce_n  (fl_ce_n)
  );

  p_one_owner_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(host_drv && ldr_drv));
  p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(host_drv || ldr_drv) |-> fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe);
endmodule

// File: tb/sim_flash_share_top.sv
module sim_flash_share_top;
  localparam int AW = 4, DW = 8, HA = 3, LA = 5, SY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_start = 0, host_wr = 0, ldr_start = 0, ldr_wr = 0;
  logic [AW-1:0] host_addr = '0, ldr_addr = '0;
  logic [DW-1:0] host_wdata = '0, ldr_wdata = '0;
  logic host_ready, host_done, ldr_ready, ldr_done;
  logic [DW-1:0] host_rdata, ldr_rdata;
  logic bus_req, bus_grant, host_drv, ldr_drv;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  int checks = 0, fails = 0, cyc = 0;
  int overlap = 0, nogrant = 0, hostgrant = 0, idlebad = 0;
  int req_t = 0, lat = -1, we_run = 0, oe_run = 0, last_we = 0, last_oe = 0, hdone_cnt = 0;
  logic prev_req = 0, prev_ld = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_share_top #(.AW(AW), .DW(DW), .HOST_ACC(HA), .LDR_ACC(LA), .SYNC_STAGES(SY)) u0 (.*);

  assign fl_dq_i = mem[fl_addr];
  always @(posedge clk) if (!fl_we_n && fl_dq_oe && !fl_ce_n) mem[fl_addr] <= fl_dq_o;

  always @(negedge clk) begin
    cyc++;
    if (host_drv && ldr_drv) overlap++;
    if (ldr_drv && !bus_grant) nogrant++;
    if (host_drv && bus_grant) hostgrant++;
    if (!host_drv && !ldr_drv && (!fl_ce_n || !fl_we_n || !fl_oe_n || fl_dq_oe)) idlebad++;
    if (bus_req && !prev_req) req_t = cyc;
    if (ldr_drv && !prev_ld) lat = cyc - req_t;
    prev_req = bus_req; prev_ld = ldr_drv;
    if (!fl_we_n) we_run++; else if (we_run != 0) begin last_we = we_run; we_run = 0; end
    if (!fl_oe_n) oe_run++; else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
    if (host_done) hdone_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic ldr_op(input bit w, input int a, input int d);
    int t = 0;
    while (!ldr_ready) @(negedge clk);
    @(posedge clk); #1;
    ldr_start = 1; ldr_wr = w; ldr_addr = AW'(a); ldr_wdata = DW'(d);
    @(posedge clk); #1;
    ldr_start = 0;
    @(negedge clk);
    while (!ldr_done && t < 200) begin
      chk(bus_req, "R6 req held", bus_req, 1);
      @(negedge clk); t++;
    end
    chk(ldr_done, "R6 loader done", ldr_done, 1);
    @(negedge clk);
    chk(!bus_req, "R6 req fell after done", bus_req, 0);
  endtask

  task automatic host_op(input bit w, input int a, input int d);
    int t = 0;
    while (!host_ready) @(negedge clk);
    @(posedge clk); #1;
    host_start = 1; host_wr = w; host_addr = AW'(a); host_wdata = DW'(d);
    @(posedge clk); #1;
    host_start = 0;
    @(negedge clk);
    while (!host_done && t < 200) begin @(negedge clk); t++; end
    chk(host_done, "R8 host done", host_done, 1);
    @(negedge clk);
  endtask

  function automatic int pat_a(int a); return (a * 7 + 3) & 8'hFF; endfunction
  function automatic int pat_b(int a); return (a ^ 8'h5A) + 16; endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!bus_req && !bus_grant, "R1 req/grant", {bus_req, bus_grant}, 0);
    chk(!host_drv && !ldr_drv && !fl_dq_oe, "R1 drivers off", {host_drv, ldr_drv, fl_dq_oe}, 0);
    chk(ldr_ready && host_ready, "R1 ready", {ldr_ready, host_ready}, 3);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R10 idle strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 7);

    // loader writes every address, host reads back
    for (int a = 0; a < (1 << AW); a++) begin
      ldr_op(1, a, pat_a(a));
      @(negedge clk);
      chk(last_we == LA, "R9 loader we width", last_we, LA);
      chk(lat == SY + 2, "R2 grant latency idle host", lat, SY + 2);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      host_op(0, a, 0);
      chk(last_oe == HA, "R8 host oe width", last_oe, HA);
      chk(int'(host_rdata) == pat_a(a), "R9 host readback", host_rdata, pat_a(a));
    end
    // host writes every address, loader reads back
    for (int a = 0; a < (1 << AW); a++) begin
      host_op(1, a, pat_b(a));
      chk(last_we == HA, "R9 host we width", last_we, HA);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      ldr_op(0, a, 0);
      @(negedge clk);
      chk(last_oe == LA, "R8 loader oe width", last_oe, LA);
      chk(int'(ldr_rdata) == (pat_b(a) & 8'hFF), "R8 loader read data", ldr_rdata, pat_b(a) & 8'hFF);
    end

    // R3: request while a host access is running
    while (!host_ready || !ldr_ready) @(negedge clk);
    @(posedge clk); #1;
    host_start = 1; host_wr = 0; host_addr = 4'd2;
    @(posedge clk); #1;
    host_start = 0;
    ldr_start = 1; ldr_wr = 0; ldr_addr = 4'd9;
    @(posedge clk); #1;
    ldr_start = 0;
    while (!ldr_done) @(negedge clk);
    chk(lat == HA + SY + 1, "R3 grant latency busy host", lat, HA + SY + 1);
    chk(int'(host_rdata) == (pat_b(2) & 8'hFF), "R3 host finished first", host_rdata, pat_b(2) & 8'hFF);
    chk(int'(ldr_rdata) == (pat_b(9) & 8'hFF), "R3 loader data", ldr_rdata, pat_b(9) & 8'hFF);

    // R4: host start during loader ownership is ignored
    repeat (12) @(negedge clk);
    begin
      int hd0;
      hd0 = hdone_cnt;
      fork
        ldr_op(0, 5, 0);
        begin
          while (!bus_grant) @(negedge clk);
          chk(!host_ready, "R4 host not ready while granted", host_ready, 0);
          @(posedge clk); #1;
          host_start = 1; host_wr = 1; host_addr = 4'd5; host_wdata = 8'hEE;
          @(posedge clk); #1;
          host_start = 0;
        end
      join
      repeat (20) @(negedge clk);
      chk(hdone_cnt == hd0, "R4 ignored host start", hdone_cnt, hd0);
      chk(int'(mem[5]) == (pat_b(5) & 8'hFF), "R4 no host write", mem[5], pat_b(5) & 8'hFF);
    end

    // R7: start during release window ignored
    ldr_op(0, 1, 0);
    chk(!ldr_ready, "R7 not ready after release", ldr_ready, 0);
    @(posedge clk); #1;
    ldr_start = 1; ldr_addr = 4'd1; ldr_wr = 0;
    @(posedge clk); #1;
    ldr_start = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (bus_req) seen++;
      end
      chk(seen == 0, "R7 no request from ignored start", seen, 0);
      chk(ldr_ready, "R7 ready after grant low", ldr_ready, 1);
    end

    chk(overlap == 0, "R5 both drivers active", overlap, 0);
    chk(nogrant == 0, "R2 loader drove without grant", nogrant, 0);
    chk(hostgrant == 0, "R4 host drove while granted", hostgrant, 0);
    chk(idlebad == 0, "R10 idle pin state", idlebad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule